// File: doc/BRIEF.md
# Dual-Buffer DMA Supervisor Register

This block is the supervisor control and status word of a data-acquisition front end. Acquisition or playback is spread over two DMA channels, A and B. A buffer-select bit names the channel that is serving requests. When that channel reports terminal count, a done flag is latched. In dual mode the buffer-select bit then flips, so the next block of transfers goes to the other channel without software stepping in.

Software writes one 16-bit word. Some of its bits are persistent controls that read back as written. The others are command strobes: they fire a single-cycle pulse and always read as zero. The block also drives an interrupt line. This line covers the done flag and, when enabled, an external error input. The DMA controllers and converters sit outside the block. Their terminal-count, scan-done and error signals arrive as plain inputs.

Top module: `dual_dma_supervisor`

## Requirements
- R1: While `rst` is high, and after it is released with no other activity, `rd_data` is 0x0000 (with `scan_done` low), `cmd_pulse` is zero, and `irq`, `active_chan`, `ext_trig_en` and `ext_clk_en` are low.
- R2: A write stores the persistent bits and they read back unchanged. The persistent bits are: bit 14 (error-interrupt enable), bit 12 (dual mode), bits 11:10 (DMA select, also driven on `dma_sel`), bit 9 (buffer B active, also driven on `active_chan`), bit 2 (external trigger enable, also driven on `ext_trig_en`) and bit 1 (external clock enable, also driven on `ext_clk_en`).
- R3: The done flag (read bit 15) sets in the cycle after terminal count on the active channel. The active channel is `dma_tc[0]` when bit 9 is 0 and `dma_tc[1]` when bit 9 is 1. Terminal count on the inactive channel is ignored.
- R4: Writing a one to bit 13 clears the done flag. If terminal count on the active channel arrives in the same cycle, the flag stays set.
- R5: With dual mode set, terminal count on the active channel toggles bit 9. Without dual mode, bit 9 does not toggle. A write in the same cycle decides bit 9 instead of the toggle.
- R6: A write with any strobe bit set produces a pulse of exactly one cycle in the cycle after the write. The strobe bits map to `cmd_pulse` as follows: bit 0 to index 0 (board init), bit 3 to index 1 (software trigger), bit 4 to index 2 (mux preload), bit 5 to index 3 (D/A init), bit 6 to index 4 (A/D init) and bit 7 to index 5 (single D/A conversion).
- R7: A write with bit 0 set returns every persistent bit and the done flag to zero. This holds whatever else the word holds and overrides a coincident terminal count. The strobes in that word still pulse.
- R8: `irq` is high while the done flag is set, or while `err_in` is high and bit 14 is set. Otherwise it is low.
- R9: Read bit 8 follows `scan_done` in the same cycle. A write to bit 8 has no effect.
- R10: Bits 13, 7, 6, 5, 4, 3 and 0 always read as zero. Writing bit 15 does not set the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write word |
| dma_tc | input | 2 | Terminal count, [0] channel A, [1] channel B |
| scan_done | input | 1 | Scan-complete status from the sequencer |
| err_in | input | 1 | Converter error indication |
| rd_data | output | 16 | Register read value |
| cmd_pulse | output | 6 | One-cycle command strobes (mapping in R6) |
| active_chan | output | 1 | Channel serving requests, 1 = B |
| dma_sel | output | 2 | DMA select field |
| ext_trig_en | output | 1 | External trigger enable |
| ext_clk_en | output | 1 | External clock enable |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several rules on every cycle. A strobe pulse must follow a write. The done flag may rise only after a terminal count, and may fall only after a clear or board-init write. The buffer bit may change without a write only when dual mode was set. Interrupt, write-only and board-init rules are checked too. The bench scenarios cover the rest: choosing the active channel while the inactive one ticks, set winning over clear in a shared cycle, and a write beating the toggle. They also cover the exact strobe bit mapping and the gating of the error interrupt.

// File: rtl/sup_pkg.sv
package sup_pkg;
    localparam int REG_W   = 16;
    localparam int NUM_CMD = 6;
    localparam int NUM_CH  = 2;

    localparam int B_DONE    = 15;
    localparam int B_ERR_EN  = 14;
    localparam int B_CLR     = 13;
    localparam int B_DUAL    = 12;
    localparam int B_SEL_HI  = 11;
    localparam int B_SEL_LO  = 10;
    localparam int B_BUF_B   = 9;
    localparam int B_SCAN    = 8;
    localparam int B_XTRIG   = 2;
    localparam int B_XCLK    = 1;
    localparam int B_BINIT   = 0;

    localparam int CMD_BINIT = 0;

    typedef struct packed {
        logic       err_irq_en;
        logic       dual_en;
        logic [1:0] dma_sel;
        logic       buf_b;
        logic       ext_trig_en;
        logic       ext_clk_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '0;

    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.err_irq_en  = w[B_ERR_EN];
        c.dual_en     = w[B_DUAL];
        c.dma_sel     = w[B_SEL_HI:B_SEL_LO];
        c.buf_b       = w[B_BUF_B];
        c.ext_trig_en = w[B_XTRIG];
        c.ext_clk_en  = w[B_XCLK];
        return c;
    endfunction

    function automatic logic [NUM_CMD-1:0] word_to_cmd(input logic [REG_W-1:0] w);
        return {w[7], w[6], w[5], w[4], w[3], w[B_BINIT]};
    endfunction

    function automatic logic [REG_W-1:0] build_read(input ctrl_t c, input logic done,
                                                    input logic scan);
        logic [REG_W-1:0] r;
        r                   = '0;
        r[B_DONE]           = done;
        r[B_ERR_EN]         = c.err_irq_en;
        r[B_DUAL]           = c.dual_en;
        r[B_SEL_HI:B_SEL_LO]= c.dma_sel;
        r[B_BUF_B]          = c.buf_b;
        r[B_SCAN]           = scan;
        r[B_XTRIG]          = c.ext_trig_en;
        r[B_XCLK]           = c.ext_clk_en;
        return r;
    endfunction
endpackage

// File: rtl/sup_ctrl_reg.sv
module sup_ctrl_reg
    import sup_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_ctrl,
    input  logic  board_init,
    input  logic  toggle_b,
    output ctrl_t ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst || board_init) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en) begin
            ctrl_q <= wr_ctrl;
        end else if (toggle_b) begin
            ctrl_q.buf_b <= ~ctrl_q.buf_b;
        end
    end
endmodule

// File: rtl/sup_dma_track.sv
module sup_dma_track
    import sup_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] dma_tc,
    input  logic          buf_b,
    input  logic          dual_en,
    input  logic          clr_req,
    input  logic          init_req,
    output logic          done_q,
    output logic          toggle_b
);
    logic active_tc;

    assign active_tc = dma_tc[buf_b];
    assign toggle_b  = dual_en & active_tc;

    always_ff @(posedge clk) begin
        if (rst || init_req) begin
            done_q <= 1'b0;
        end else if (active_tc) begin
            done_q <= 1'b1;
        end else if (clr_req) begin
            done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sup_cmd_pulse.sv
module sup_cmd_pulse #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] cmd_bits,
    output logic [N-1:0] pulse_q
);
    for (genvar i = 0; i < N; i++) begin : g_strobe
        always_ff @(posedge clk) begin
            if (rst) begin
                pulse_q[i] <= 1'b0;
            end else begin
                pulse_q[i] <= wr_en & cmd_bits[i];
            end
        end
    end
endmodule

// File: rtl/dual_dma_supervisor.sv
module dual_dma_supervisor
    import sup_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [NUM_CH-1:0]  dma_tc,
    input  logic               scan_done,
    input  logic               err_in,
    output logic [REG_W-1:0]   rd_data,
    output logic [NUM_CMD-1:0] cmd_pulse,
    output logic               active_chan,
    output logic [1:0]         dma_sel,
    output logic               ext_trig_en,
    output logic               ext_clk_en,
    output logic               irq
);
    ctrl_t ctrl_q;
    ctrl_t wr_ctrl;
    logic  board_init;
    logic  clr_req;
    logic  toggle_b;
    logic  done_q;
    logic  unused_ro_bits;

    assign wr_ctrl        = word_to_ctrl(wr_data);
    assign board_init     = wr_en & wr_data[B_BINIT];
    assign clr_req        = wr_en & wr_data[B_CLR];
    assign unused_ro_bits = &{1'b0, wr_data[B_DONE], wr_data[B_SCAN]};

    sup_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_ctrl    (wr_ctrl),
        .board_init (board_init),
        .toggle_b   (toggle_b),
        .ctrl_q     (ctrl_q)
    );

    sup_dma_track #(.CH(NUM_CH)) u_track (
        .clk      (clk),
        .rst      (rst),
        .dma_tc   (dma_tc),
        .buf_b    (ctrl_q.buf_b),
        .dual_en  (ctrl_q.dual_en),
        .clr_req  (clr_req),
        .init_req (board_init),
        .done_q   (done_q),
        .toggle_b (toggle_b)
    );

    sup_cmd_pulse #(.N(NUM_CMD)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .cmd_bits (word_to_cmd(wr_data)),
        .pulse_q  (cmd_pulse)
    );

    assign rd_data     = build_read(ctrl_q, done_q, scan_done);
    assign active_chan = ctrl_q.buf_b;
    assign dma_sel     = ctrl_q.dma_sel;
    assign ext_trig_en = ctrl_q.ext_trig_en;
    assign ext_clk_en  = ctrl_q.ext_clk_en;
    assign irq         = done_q | (err_in & ctrl_q.err_irq_en);
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [1:0]  dma_tc,
    input logic        err_in,
    input logic [15:0] rd_data,
    input logic [5:0]  cmd_pulse,
    input logic        active_chan,
    input logic        irq
);
    assert_pulse_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_pulse != 6'd0) |-> $past(wr_en));

    assert_done_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[15]) |-> $past(dma_tc != 2'b00));

    assert_done_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[15]) |-> $past(wr_en && (wr_data[13] || wr_data[0])));

    assert_chan_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(active_chan) && !$past(wr_en)) |-> ($past(rd_data[12]) && $past(dma_tc != 2'b00)));

    assert_irq_on_done_R8: assert property (@(posedge clk) disable iff (rst)
        rd_data[15] |-> irq);

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[15] && !err_in) |-> !irq);

    assert_wo_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_data & 16'h20F9) == 16'h0000);

    assert_board_init_R7: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_data[0]) |-> ((rd_data & 16'hDE06) == 16'h0000));
endmodule

bind dual_dma_supervisor sup_checker u_sup_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .dma_tc      (dma_tc),
    .err_in      (err_in),
    .rd_data     (rd_data),
    .cmd_pulse   (cmd_pulse),
    .active_chan (active_chan),
    .irq         (irq)
);

// File: tb/dual_dma_supervisor_bench.sv
module dual_dma_supervisor_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  dma_tc = '0;
    logic        scan_done = 1'b0;
    logic        err_in = 1'b0;
    logic [15:0] rd_data;
    logic [5:0]  cmd_pulse;
    logic        active_chan;
    logic [1:0]  dma_sel;
    logic        ext_trig_en;
    logic        ext_clk_en;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit armed = 0;
    bit finished = 0;

    logic [15:0] m_p = '0;
    logic        m_done = 1'b0;
    logic [5:0]  m_pulse = '0;

    always #5 clk = ~clk;

    dual_dma_supervisor u_dual_dma_supervisor (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .dma_tc(dma_tc),
        .scan_done(scan_done), .err_in(err_in), .rd_data(rd_data),
        .cmd_pulse(cmd_pulse), .active_chan(active_chan), .dma_sel(dma_sel),
        .ext_trig_en(ext_trig_en), .ext_clk_en(ext_clk_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [15:0] exp_rd;
        exp_rd = m_p | ({15'd0, m_done} << 15) | ({15'd0, scan_done} << 8);
        chk("R2 persistent bits", rd_data & 16'h5E06, m_p);
        chk("R3 done flag", {15'd0, rd_data[15]}, {15'd0, m_done});
        chk("R9 scan bit", {15'd0, rd_data[8]}, {15'd0, scan_done});
        chk("R10 write-only bits", rd_data & 16'h20F9, 16'h0000);
        chk("R2 full read", rd_data, exp_rd);
        chk("R5 active channel", {15'd0, active_chan}, {15'd0, m_p[9]});
        chk("R2 dma_sel", {14'd0, dma_sel}, {14'd0, m_p[11:10]});
        chk("R2 ext enables", {14'd0, ext_trig_en, ext_clk_en}, {14'd0, m_p[2], m_p[1]});
        chk("R6 pulses", {10'd0, cmd_pulse}, {10'd0, m_pulse});
        chk("R8 irq", {15'd0, irq}, {15'd0, m_done | (err_in & m_p[14])});
    endtask

    task automatic model_edge();
        logic atc, tog;
        if (rst) begin
            m_p = '0; m_done = 1'b0; m_pulse = '0;
        end else begin
            atc = m_p[9] ? dma_tc[1] : dma_tc[0];
            tog = m_p[12] && atc;
            m_pulse = wr_en ? {wr_data[7], wr_data[6], wr_data[5], wr_data[4], wr_data[3], wr_data[0]} : 6'd0;
            if (wr_en && wr_data[0]) begin
                m_p = '0; m_done = 1'b0;
            end else begin
                if (wr_en) m_p = wr_data & 16'h5E06;
                else if (tog) m_p[9] = ~m_p[9];
                if (atc) m_done = 1'b1;
                else if (wr_en && wr_data[13]) m_done = 1'b0;
            end
        end
    endtask

    task automatic step(input logic r, input logic we, input logic [15:0] d,
                        input logic [1:0] tc, input logic sc, input logic er);
        rst = r; wr_en = we; wr_data = d; dma_tc = tc; scan_done = sc; err_in = er;
        #1;
        if (armed) compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 16'h0000, 2'b00, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 16'h0000, 2'b00, 0, 0);
        armed = 1;
        step(1, 1, 16'hFFFF, 2'b11, 0, 1);
        step(0, 0, 16'h0000, 2'b00, 0, 0);
        #1;
        // R1: quiet state after reset
        chk("R1 reset read", rd_data, 16'h0000);
        chk("R1 reset irq", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        // R2: persistent patterns
        step(0, 1, 16'h4C06, 2'b00, 0, 0);
        idle(1);
        step(0, 1, 16'h0A02, 2'b00, 0, 0);
        idle(1);
        // R10: write-only and read-only bits; R6 strobes mapping
        step(0, 1, 16'hA1F8, 2'b00, 0, 0);
        idle(2);
        // R3: inactive channel ignored, then active sets done
        step(0, 0, 16'h0000, 2'b10, 0, 0);
        step(0, 0, 16'h0000, 2'b01, 0, 0);
        idle(1);
        // R4: clear, then clear together with terminal count
        step(0, 1, 16'h2000, 2'b00, 0, 0);
        #1;
        chk("R4 done cleared", {15'd0, rd_data[15]}, 16'h0000);
        @(negedge clk);
        step(0, 1, 16'h2000, 2'b01, 0, 0);
        #1;
        chk("R4 set wins over clear", {15'd0, rd_data[15]}, 16'h0001);
        @(negedge clk);
        // R5: dual mode toggling
        step(0, 1, 16'h3000, 2'b00, 0, 0);
        step(0, 0, 16'h0000, 2'b01, 0, 0);
        step(0, 0, 16'h0000, 2'b01, 0, 0);
        step(0, 0, 16'h0000, 2'b10, 0, 0);
        idle(1);
        step(0, 1, 16'h1200, 2'b01, 0, 0);
        step(0, 0, 16'h0000, 2'b10, 0, 0);
        idle(1);
        // R5: no toggle without dual mode
        step(0, 1, 16'h2000, 2'b00, 0, 0);
        step(0, 0, 16'h0000, 2'b01, 0, 0);
        idle(1);
        // R8: error interrupt gating
        step(0, 1, 16'h2000, 2'b00, 0, 1);
        step(0, 0, 16'h0000, 2'b00, 0, 1);
        step(0, 1, 16'h4000, 2'b00, 0, 1);
        step(0, 0, 16'h0000, 2'b00, 0, 1);
        step(0, 0, 16'h0000, 2'b00, 0, 0);
        // R9: scan done pass-through
        step(0, 1, 16'h0100, 2'b00, 1, 0);
        step(0, 0, 16'h0000, 2'b00, 0, 0);
        step(0, 0, 16'h0000, 2'b00, 1, 0);
        // R7: board init clears everything
        step(0, 1, 16'h5E06, 2'b00, 0, 0);
        step(0, 0, 16'h0000, 2'b01, 0, 0);
        step(0, 1, 16'h5E07, 2'b01, 0, 0);
        #1;
        chk("R7 board init read", rd_data, 16'h0000);
        chk("R7 board init pulse", {10'd0, cmd_pulse}, 16'h0001);
        @(negedge clk);
        idle(3);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule